// File: doc/BRIEF.md
# Key-Protected Configuration Register File

This block is a bank of configuration registers on a simple 32-bit register bus. The bus has a valid strobe, a write enable, a 12-bit byte offset, write data and registered read data. A single write-protection flag guards everything at offset 0x100 and above. Software arms the protection by writing one 16-bit key to a dedicated offset and disarms it by writing a different key to another offset. Reads are never blocked.

A one-bit control register and the protection status stay reachable at all times in the low control window. The protected space holds a group of clock-generator control and configuration words with fixed reset values, a generic bank of words and a second bank with a hole. Register contents leave the block only as output ports. Any write the block refuses produces a one-cycle error pulse, so a system can detect writes that were lost.

Top module: `keyed_cfg_regs`

## Requirements
- R1: After reset the protection flag is 1 and the control bit is 0. Each clock-control word (0x100, 0x104, 0x108) holds 0x0001A008 and each clock-configuration word (0x110, 0x114, 0x118) holds 0x00014000. Every other stored word, `bus_rdata` and `wr_err` are 0.
- R2: A write to 0x8 whose bits [15:0] equal 0xDF0D clears the flag, whatever bits [31:16] hold. Any other value written there leaves the flag unchanged. A read of 0x8 returns 0.
- R3: A write to 0x4 whose bits [15:0] equal 0x767B sets the flag. Any other value written there leaves the flag unchanged. A read of 0x4 returns 0.
- R4: A read of 0xC returns the flag in bit 0, with bits [31:1] zero. Writes to 0xC change nothing and raise no error.
- R5: While the flag is 1, every write to an offset of 0x100 or above is discarded and raises the error pulse. Reads there still return the stored values.
- R6: A write to 0x0 stores only bit 0 of the data, whether or not the flag is set. A read of 0x0 returns that bit in bit 0.
- R7: While the flag is 0, a write stores all 32 bits at a mapped word, and a later read returns it. The mapped words are 0x100/0x104/0x108 (`clk_ctl_o` slots 0..2), 0x110/0x114/0x118 (`clk_cfg_o` slots 0..2), 0x11C (`clk_aux_o`), 0x200+4*i for i < BANK_N (`bank_o` slot i), and 0x600+4*i for i < DDR_N with i != 1 (`ddr_o` slot i).
- R8: Holes discard writes even while the flag is 0, and each such write raises the error pulse. 0x10C reads 0x0000003F, 0x604 reads 0, 0x25C reads 1, and every other offset outside R2-R7 reads 0. Offsets that are not multiples of 4 count as holes.
- R9: `bus_rdata` takes the value read by an access in the clock edge that ends the access. It keeps that value through writes and idle cycles.
- R10: A key write takes effect for the very next access: a protected write issued in the cycle right after the key write already sees the new flag.
- R11: `wr_err` is 1 for exactly the one cycle after each discarded write. It is 0 after accepted writes, reads and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_vld | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (12) | Byte offset |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data |
| wr_err | output | 1 | One-cycle pulse after a discarded write |
| locked | output | 1 | Protection flag |
| ctl_bit | output | 1 | One-bit control register |
| clk_ctl_o | output | 3*DW | Clock-control words, slot 0 in the low bits |
| clk_cfg_o | output | 3*DW | Clock-configuration words, slot 0 in the low bits |
| clk_aux_o | output | DW | Auxiliary clock word |
| bank_o | output | BANK_N*DW | Generic bank, slot 0 in the low bits |
| ddr_o | output | DDR_N*DW | Second bank, slot 1 always zero |

## Verification
The bench builds the block with BANK_N = 16 and DDR_N = 9. With these values the generic bank ends at 0x23C, which leaves 0x240-0x258 as reachable unmapped words just below the fixed 0x25C word. The second bank also spans 0x600-0x620, so its hole lands at 0x604. Random accesses are drawn mostly from the control window, the clock group, both bank edges and those holes. Correct keys appear often enough for the flag to toggle many times. Directed sequences place key writes directly before protected writes.

// File: rtl/keyed_cfg_regs.sv
module keyed_cfg_regs #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int BANK_N = 16,
  parameter int DDR_N = 9,
  parameter logic [15:0] LOCK_KEY = 16'h767B,
  parameter logic [15:0] UNLOCK_KEY = 16'hDF0D,
  parameter logic [DW-1:0] CTL_RST = 32'h0001A008,
  parameter logic [DW-1:0] CFG_RST = 32'h00014000,
  parameter logic [DW-1:0] STAT_VAL = 32'h0000003F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_vld,
  input  logic                 bus_we,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic                 wr_err,
  output logic                 locked,
  output logic                 ctl_bit,
  output logic [3*DW-1:0]      clk_ctl_o,
  output logic [3*DW-1:0]      clk_cfg_o,
  output logic [DW-1:0]        clk_aux_o,
  output logic [BANK_N*DW-1:0] bank_o,
  output logic [DDR_N*DW-1:0]  ddr_o
);
  localparam logic [AW-1:0] A_CTL    = AW'(12'h000);
  localparam logic [AW-1:0] A_LOCK   = AW'(12'h004);
  localparam logic [AW-1:0] A_UNLOCK = AW'(12'h008);
  localparam logic [AW-1:0] A_STAT   = AW'(12'h00C);
  localparam logic [AW-1:0] A_ONE    = AW'(12'h25C);
  localparam int PLL_BASE  = 'h100;
  localparam int BANK_BASE = 'h200;
  localparam int DDR_BASE  = 'h600;
  localparam int PLL_HOLE  = 3;
  localparam int DDR_HOLE  = 1;
  localparam int BIW = (BANK_N > 1) ? $clog2(BANK_N) : 1;
  localparam int DIW = (DDR_N > 1) ? $clog2(DDR_N) : 1;

  logic [DW-1:0] pll_r  [8];
  logic [DW-1:0] bank_r [BANK_N];
  logic [DW-1:0] ddr_r  [DDR_N];

  logic          aligned, pll_hit, bank_hit, ddr_hit, ctl_space, writable;
  logic          wr, wr_ok, rd;
  logic [AW-1:0] boff, doff;
  logic [2:0]    pidx;
  logic [BIW-1:0] bidx;
  logic [DIW-1:0] didx;
  logic [DW-1:0] rd_val;

  assign aligned   = bus_addr[1:0] == 2'b00;
  assign boff      = bus_addr - AW'(BANK_BASE);
  assign doff      = bus_addr - AW'(DDR_BASE);
  assign pidx      = bus_addr[4:2];
  assign bidx      = boff[BIW+1:2];
  assign didx      = doff[DIW+1:2];
  assign pll_hit   = aligned && bus_addr[AW-1:5] == (AW-5)'(PLL_BASE >> 5);
  assign bank_hit  = aligned && {20'd0, bus_addr} >= BANK_BASE && {20'd0, bus_addr} < BANK_BASE + 4*BANK_N;
  assign ddr_hit   = aligned && {20'd0, bus_addr} >= DDR_BASE && {20'd0, bus_addr} < DDR_BASE + 4*DDR_N;
  assign ctl_space = bus_addr == A_CTL || bus_addr == A_LOCK || bus_addr == A_UNLOCK || bus_addr == A_STAT;
  assign writable  = (pll_hit && pidx != 3'(PLL_HOLE)) || bank_hit || (ddr_hit && didx != DIW'(DDR_HOLE));
  assign wr        = bus_vld && bus_we;
  assign rd        = bus_vld && !bus_we;
  assign wr_ok     = wr && !locked && writable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked  <= 1'b1;
      ctl_bit <= 1'b0;
      wr_err  <= 1'b0;
    end else begin
      wr_err <= wr && !ctl_space && !wr_ok;
      if (wr && bus_addr == A_CTL) ctl_bit <= bus_wdata[0];
      if (wr && bus_addr == A_LOCK && bus_wdata[15:0] == LOCK_KEY) locked <= 1'b1;
      if (wr && bus_addr == A_UNLOCK && bus_wdata[15:0] == UNLOCK_KEY) locked <= 1'b0;
    end
  end

  for (genvar g = 0; g < 8; g++) begin : g_pll
    localparam logic [DW-1:0] RST = (g < 3) ? CTL_RST : (g > 3 && g < 7) ? CFG_RST : '0;
    if (g == PLL_HOLE) begin : g_stat
      assign pll_r[g] = STAT_VAL;
    end else begin : g_word
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pll_r[g] <= RST;
        else if (wr_ok && pll_hit && pidx == 3'(g)) pll_r[g] <= bus_wdata;
    end
  end

  for (genvar g = 0; g < BANK_N; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) bank_r[g] <= '0;
      else if (wr_ok && bank_hit && bidx == BIW'(g)) bank_r[g] <= bus_wdata;
    assign bank_o[g*DW +: DW] = bank_r[g];
  end

  for (genvar g = 0; g < DDR_N; g++) begin : g_ddr
    if (g == DDR_HOLE) begin : g_hole
      assign ddr_r[g] = '0;
    end else begin : g_word
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ddr_r[g] <= '0;
        else if (wr_ok && ddr_hit && didx == DIW'(g)) ddr_r[g] <= bus_wdata;
    end
    assign ddr_o[g*DW +: DW] = ddr_r[g];
  end

  assign clk_ctl_o = {pll_r[2], pll_r[1], pll_r[0]};
  assign clk_cfg_o = {pll_r[6], pll_r[5], pll_r[4]};
  assign clk_aux_o = pll_r[7];

  always_comb begin
    rd_val = '0;
    if (bus_addr == A_CTL)  rd_val = DW'(ctl_bit);
    if (bus_addr == A_STAT) rd_val = DW'(locked);
    if (bus_addr == A_ONE)  rd_val = DW'(1);
    for (int i = 0; i < 8; i++)
      if (pll_hit && pidx == 3'(i)) rd_val = pll_r[i];
    for (int i = 0; i < BANK_N; i++)
      if (bank_hit && bidx == BIW'(i)) rd_val = bank_r[i];
    for (int i = 0; i < DDR_N; i++)
      if (ddr_hit && didx == DIW'(i)) rd_val = ddr_r[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_val;
endmodule

// File: rtl/keyed_cfg_regs_chk.sv
module keyed_cfg_regs_chk #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int BANK_N = 16,
  parameter int DDR_N = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_vld,
  input logic                 bus_we,
  input logic [AW-1:0]        bus_addr,
  input logic [DW-1:0]        bus_wdata,
  input logic [DW-1:0]        bus_rdata,
  input logic                 wr_err,
  input logic                 locked,
  input logic [3*DW-1:0]      clk_ctl_o,
  input logic [3*DW-1:0]      clk_cfg_o,
  input logic [DW-1:0]        clk_aux_o,
  input logic [BANK_N*DW-1:0] bank_o,
  input logic [DDR_N*DW-1:0]  ddr_o
);
  // R2
  unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_vld && bus_we && bus_addr == 12'h008 && bus_wdata[15:0] == 16'hDF0D |=> !locked);
  // R3
  lock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_vld && bus_we && bus_addr == 12'h004 && bus_wdata[15:0] == 16'h767B |=> locked);
  // R4
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_vld && !bus_we && bus_addr == 12'h00C |=> bus_rdata == DW'($past(locked)));
  // R5
  locked_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_vld && bus_we && locked && bus_addr >= 12'h100 |=> wr_err);
  // R5
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(clk_ctl_o) && $stable(clk_cfg_o) && $stable(clk_aux_o) && $stable(bank_o) && $stable(ddr_o));
  // R8
  fixed_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_vld && !bus_we && bus_addr == 12'h25C |=> bus_rdata == DW'(1));
  // R11
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(bus_vld && bus_we));
endmodule

bind keyed_cfg_regs keyed_cfg_regs_chk #(.AW(AW), .DW(DW), .BANK_N(BANK_N), .DDR_N(DDR_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_err(wr_err), .locked(locked),
  .clk_ctl_o(clk_ctl_o), .clk_cfg_o(clk_cfg_o), .clk_aux_o(clk_aux_o),
  .bank_o(bank_o), .ddr_o(ddr_o));

// File: tb/keyed_cfg_regs_bench.sv
module keyed_cfg_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BANK_N = 16;
  localparam int DDR_N = 9;

  logic clk = 0, rst_n = 0;
  logic bus_vld = 0, bus_we = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic wr_err, locked, ctl_bit;
  logic [95:0] clk_ctl_o, clk_cfg_o;
  logic [31:0] clk_aux_o;
  logic [BANK_N*32-1:0] bank_o;
  logic [DDR_N*32-1:0] ddr_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_cfg_regs #(.BANK_N(BANK_N), .DDR_N(DDR_N)) u_keyed_cfg_regs (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_err(wr_err), .locked(locked),
    .ctl_bit(ctl_bit), .clk_ctl_o(clk_ctl_o), .clk_cfg_o(clk_cfg_o), .clk_aux_o(clk_aux_o),
    .bank_o(bank_o), .ddr_o(ddr_o));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_reg [0:1023];
  logic m_locked, m_ctl;
  logic [31:0] m_rdata;

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_writable(logic [11:0] a);
    if (a[1:0] != 0) return 0;
    if (a >= 12'h100 && a <= 12'h11C && a != 12'h10C) return 1;
    if (int'(a) >= 'h200 && int'(a) < 'h200 + 4*BANK_N) return 1;
    if (int'(a) >= 'h600 && int'(a) < 'h600 + 4*DDR_N && a != 12'h604) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    if (a == 12'h000) return {31'd0, m_ctl};
    if (a == 12'h00C) return {31'd0, m_locked};
    if (a == 12'h10C) return 32'h3F;
    if (a == 12'h25C) return 32'd1;
    if (m_writable(a)) return m_reg[a[11:2]];
    return 32'd0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 1024; i++) m_reg[i] = 0;
    for (int i = 0; i < 3; i++) begin
      m_reg[('h100 >> 2) + i] = 32'h0001A008;
      m_reg[('h110 >> 2) + i] = 32'h00014000;
    end
    m_locked = 1; m_ctl = 0; m_rdata = 0;
  endtask

  // caller is at a negedge; inputs stay applied until the next call
  task automatic acc(bit we, logic [11:0] a, logic [31:0] d, string tag);
    bit e_err = 0;
    if (!we) m_rdata = m_read(a);
    else if (a == 12'h000) m_ctl = d[0];
    else if (a == 12'h004) begin if (d[15:0] == 16'h767B) m_locked = 1; end
    else if (a == 12'h008) begin if (d[15:0] == 16'hDF0D) m_locked = 0; end
    else if (a == 12'h00C) ;
    else if (!m_locked && m_writable(a)) m_reg[a[11:2]] = d;
    else e_err = 1;
    bus_vld = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    check({tag, " err"}, 128'(wr_err), 128'(e_err));
    check({tag, " rdata"}, 128'(bus_rdata), 128'(m_rdata));
    check({tag, " lock"}, 128'(locked), 128'(m_locked));
    check({tag, " ctl"}, 128'(ctl_bit), 128'(m_ctl));
  endtask

  task automatic idle(string tag);
    bus_vld = 0; bus_we = 0;
    @(negedge clk);
    check({tag, " idle err"}, 128'(wr_err), 128'(0));
    check({tag, " idle rdata"}, 128'(bus_rdata), 128'(m_rdata));
  endtask

  task automatic check_ports(string tag);
    for (int i = 0; i < 3; i++) begin
      check({tag, " clk_ctl"}, 128'(clk_ctl_o[i*32 +: 32]), 128'(m_reg[('h100 >> 2) + i]));
      check({tag, " clk_cfg"}, 128'(clk_cfg_o[i*32 +: 32]), 128'(m_reg[('h110 >> 2) + i]));
    end
    check({tag, " clk_aux"}, 128'(clk_aux_o), 128'(m_reg['h11C >> 2]));
    for (int i = 0; i < BANK_N; i++)
      check({tag, " bank"}, 128'(bank_o[i*32 +: 32]), 128'(m_reg[('h200 >> 2) + i]));
    for (int i = 0; i < DDR_N; i++)
      check({tag, " ddr"}, 128'(ddr_o[i*32 +: 32]), 128'(m_reg[('h600 >> 2) + i]));
  endtask

  function automatic logic [11:0] pick_addr();
    int s = int'($urandom_range(0, 9));
    case (s)
      0: return 12'(4 * $urandom_range(0, 3));
      1, 2: return 12'('h100 + 4 * $urandom_range(0, 7));
      3, 4: return 12'('h200 + 4 * $urandom_range(0, BANK_N + 1));
      5: return 12'($urandom_range(0, 1) ? 'h25C : 'h258);
      6, 7: return 12'('h600 + 4 * $urandom_range(0, DDR_N));
      8: return 12'(4 + 4 * $urandom_range(0, 1));
      default: return 12'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state at the ports
    check("R1 locked", 128'(locked), 128'(1));
    check("R1 ctl", 128'(ctl_bit), 128'(0));
    check("R1 err", 128'(wr_err), 128'(0));
    check("R1 rdata", 128'(bus_rdata), 128'(0));
    check_ports("R1");
    acc(0, 12'h100, 0, "R1 read ctl word");
    acc(0, 12'h114, 0, "R1 read cfg word");
    acc(0, 12'h00C, 0, "R4 status locked");
    // R5 locked writes dropped, reads still work
    acc(1, 12'h104, 32'hDEADBEEF, "R5 locked write");
    acc(0, 12'h104, 0, "R5 locked readback");
    acc(1, 12'h200, 32'h12345678, "R5 locked bank write");
    check_ports("R5");
    // R6 control bit while locked
    acc(1, 12'h000, 32'hFFFF_FFFF, "R6 set");
    acc(0, 12'h000, 0, "R6 read");
    acc(1, 12'h000, 32'hFFFF_FFFE, "R6 clear");
    acc(0, 12'h000, 0, "R6 read zero");
    // R2 wrong key, R4 writes ignored
    acc(1, 12'h008, 32'h0000DF0C, "R2 wrong key");
    acc(1, 12'h00C, 32'h0, "R4 write ignored");
    acc(0, 12'h00C, 0, "R4 still locked");
    acc(0, 12'h008, 0, "R2 read zero");
    // R10 unlock then immediate write
    acc(1, 12'h008, 32'hABCD_DF0D, "R2 unlock upper junk");
    acc(1, 12'h104, 32'hCAFE0001, "R10 write after unlock");
    acc(0, 12'h104, 0, "R7 readback");
    acc(0, 12'h00C, 0, "R4 status unlocked");
    acc(1, 12'h11C, 32'h5A5A5A5A, "R7 aux");
    acc(1, 12'h23C, 32'hA5A5_0F0F, "R7 bank top");
    acc(1, 12'h620, 32'h1111_2222, "R7 ddr top");
    idle("R9");
    // R8 holes
    acc(1, 12'h10C, 32'hFFFF_FFFF, "R8 status hole write");
    acc(0, 12'h10C, 0, "R8 status reads 3F");
    acc(1, 12'h604, 32'hFFFF_FFFF, "R8 ddr hole write");
    acc(0, 12'h604, 0, "R8 ddr hole reads 0");
    acc(1, 12'h25C, 32'h0, "R8 fixed word write");
    acc(0, 12'h25C, 0, "R8 fixed word reads 1");
    acc(1, 12'h240, 32'h77, "R8 unmapped past bank");
    acc(1, 12'h102, 32'h77, "R8 unaligned");
    acc(0, 12'h240, 0, "R8 unmapped read");
    acc(1, 12'h010, 32'h77, "R8 low unmapped");
    idle("R11");
    // R3 wrong lock key, then lock and immediate write
    acc(1, 12'h004, 32'h0000767C, "R3 wrong key");
    acc(1, 12'h108, 32'h0BAD_F00D, "R7 still unlocked");
    acc(1, 12'h004, 32'hFFFF_767B, "R3 lock");
    acc(1, 12'h200, 32'h9999_9999, "R10 write after lock");
    acc(0, 12'h004, 0, "R3 read zero");
    check_ports("R7");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a = pick_addr();
      logic [31:0] d = $urandom;
      bit we = $urandom_range(0, 1) == 1;
      if (a == 12'h004 && $urandom_range(0, 1) == 1) d[15:0] = 16'h767B;
      if (a == 12'h008 && $urandom_range(0, 2) != 0) d[15:0] = 16'hDF0D;
      if ($urandom_range(0, 7) == 0) idle("R9 R11 random");
      else acc(we, a, d, "R7 R5 R8 random");
    end
    idle("R9 end");
    check_ports("R7 R5 end");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule